// File: doc/BRIEF.md
# Pixel Histogram Bin Accumulator

This block counts pixel values into a 1024-entry table of 24-bit bins. Each clock a 10-bit pixel value addresses one bin. The bin is read, a step value is added to it, and the sum is written back to the same bin. The result also appears on a registered 24-bit output. In histogram mode the step is one. In bin-accumulate mode the step is the 24-bit data input presented with the pixel.

The enable input is active low. While it is high, bins are still read and their contents appear on the output, but nothing is written back. The enable and the step travel down the three-stage pipeline with their pixel. When the same bin arrives on back-to-back clocks, the sum still being written is forwarded into the adder, so no update is lost.

An active-low clear request empties the pipeline and starts a sweep that writes zero to all 1024 bins, one per clock. A busy flag is high during the sweep, and pixels are ignored until it ends. Reset starts the same sweep. The output is gated by an active-low read enable and comes with a valid flag in place of a tri-state bus.

Top module: `pix_hist_acc`

## Requirements
- R1: In histogram mode (mode_sel = 0) with start_n low, the bin addressed by pix_in is incremented by one and written back. The new count appears on dout with dout_valid high after the third rising clock edge that follows the capture of pix_in, counting the capture edge as the first.
- R2: In bin-accumulate mode (mode_sel = 1) with start_n low, din is added to the addressed bin instead of one, with the same latency as R1. In histogram mode din has no effect.
- R3: Sums wrap modulo 2^24. A bin holding 0xFFFFFF that receives a step of 2 becomes 0x000001.
- R4: With start_n high the addressed bin is output unchanged and is not written. A later read of that bin returns the same value.
- R5: A bin addressed on consecutive clocks, or two clocks apart, receives every update. Three enabled histogram hits in a row on an empty bin output 1, 2 and 3.
- R6: clr_n sampled low at a rising edge starts a sweep. busy is high for exactly 1024 clock cycles from that edge, and afterwards every bin reads zero.
- R7: While busy is high, pixel inputs are ignored: dout_valid stays low and no bin changes.
- R8: After reset, busy is high and dout_valid is low. The reset sweep ends between 1024 and 1030 cycles after rst_n rises.
- R9: With rd_n high, dout_valid is low and dout reads zero. With rd_n low the registered result is driven.
- R10: A change of mode_sel empties the pipeline. On the two cycles after the first rising edge that sees the new mode, dout_valid is low and dout is zero.
- R11: On the cycle after clr_n is sampled low, dout_valid is low and dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 1 | 0 = histogram (step one), 1 = bin accumulate (step din) |
| start_n | input | 1 | Active-low update enable, travels with its pixel |
| pix_in | input | 10 | Pixel value, selects the bin |
| din | input | 24 | Step value used in bin-accumulate mode |
| clr_n | input | 1 | Active-low clear request, starts the zeroing sweep |
| rd_n | input | 1 | Active-low output enable |
| dout | output | 24 | Registered bin result, zero while rd_n is high |
| dout_valid | output | 1 | dout carries a result for a pixel |
| busy | output | 1 | Zeroing sweep in progress |

## Verification
Several properties hold on every cycle and are checked there:
- no valid output during a sweep,
- the pipeline is emptied after a clear request or a mode change,
- a sweep never ends on a cycle that asked for a clear,
- a sweep never runs longer than its bound.

Other behaviour only shows over a scenario, and the bench's sequences cover it by reading bins back. This covers the arithmetic of counting and accumulating, wrap-around, forwarding between back-to-back hits on one bin, the absence of writes while disabled or busy, and the zeroed table after a sweep.

// File: rtl/pha_pkg.sv
package pha_pkg;
  typedef enum logic {
    MODE_HIST = 1'b0,
    MODE_BIN  = 1'b1
  } pha_mode_e;
endpackage

// File: rtl/pha_reset_sync.sv
module pha_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/pha_sweep.sv
module pha_sweep #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_req,
  output logic          busy,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic          busy_q, busy_d;
  logic [AW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (clr_req) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      busy_d = (cnt_q != LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign addr = cnt_q;
endmodule

// File: rtl/pha_ram.sv
module pha_ram #(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pha_update.sv
module pha_update #(
  parameter int DW = 24
) (
  input  logic          fwd,
  input  logic [DW-1:0] fwd_val,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] step,
  output logic [DW-1:0] operand,
  output logic [DW-1:0] sum
);
  always_comb begin
    operand = fwd ? fwd_val : rdata;
    sum     = operand + step;
  end
endmodule

// File: rtl/pix_hist_acc.sv
module pix_hist_acc
  import pha_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             start_n,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [CNT_W-1:0] din,
  input  logic             clr_n,
  input  logic             rd_n,
  output logic [CNT_W-1:0] dout,
  output logic             dout_valid,
  output logic             busy
);
  logic rst_s_n;
  logic clr_hit, mode_chg, flush;
  pha_mode_e mode_q;

  // stage 1: captured pixel, enable and step
  logic             s1_vld_q, s1_vld_d, s1_upd_q, s1_upd_d;
  logic [PIX_W-1:0] s1_addr_q, s1_addr_d;
  logic [CNT_W-1:0] s1_add_q, s1_add_d;
  // stage 2: memory word read, update computed
  logic             s2_vld_q, s2_vld_d, s2_upd_q, s2_upd_d;
  logic [PIX_W-1:0] s2_addr_q, s2_addr_d;
  logic [CNT_W-1:0] s2_add_q, s2_add_d;
  logic             fwd_q, fwd_d;
  // stage 3: output register
  logic             out_vld_q, out_vld_d;
  logic [CNT_W-1:0] out_q, out_d;

  logic             s2_wr;
  logic [CNT_W-1:0] rdata, operand, sum;
  logic [PIX_W-1:0] sw_addr;
  logic             ram_we;
  logic [PIX_W-1:0] ram_waddr;
  logic [CNT_W-1:0] ram_wdata;

  pha_reset_sync rst_i (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  assign clr_hit  = !clr_n;
  assign mode_chg = (pha_mode_e'(mode_sel) != mode_q);
  assign flush    = clr_hit | busy | mode_chg;
  assign s2_wr    = s2_vld_q & s2_upd_q;

  pha_sweep #(.AW(PIX_W)) sweep_i (
    .clk(clk), .rst_n(rst_s_n), .clr_req(clr_hit), .busy(busy), .addr(sw_addr)
  );

  assign ram_we    = busy | s2_wr;
  assign ram_waddr = busy ? sw_addr : s2_addr_q;
  assign ram_wdata = busy ? '0 : sum;

  pha_ram #(.AW(PIX_W), .DW(CNT_W)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(s1_vld_q), .raddr(s1_addr_q), .rdata(rdata)
  );

  pha_update #(.DW(CNT_W)) upd_i (
    .fwd(fwd_q), .fwd_val(out_q), .rdata(rdata), .step(s2_add_q),
    .operand(operand), .sum(sum)
  );

  always_comb begin
    s1_vld_d  = 1'b0;
    s1_upd_d  = 1'b0;
    s1_addr_d = '0;
    s1_add_d  = '0;
    s2_vld_d  = 1'b0;
    s2_upd_d  = 1'b0;
    s2_addr_d = '0;
    s2_add_d  = '0;
    fwd_d     = 1'b0;
    out_vld_d = 1'b0;
    out_d     = '0;
    if (!flush) begin
      s1_vld_d  = 1'b1;
      s1_upd_d  = !start_n;
      s1_addr_d = pix_in;
      s1_add_d  = (pha_mode_e'(mode_sel) == MODE_BIN) ? din : CNT_W'(1);
      s2_vld_d  = s1_vld_q;
      s2_upd_d  = s1_upd_q;
      s2_addr_d = s1_addr_q;
      s2_add_d  = s1_add_q;
      fwd_d     = s1_vld_q & s2_wr & (s1_addr_q == s2_addr_q);
      out_vld_d = s2_vld_q;
      out_d     = s2_vld_q ? (s2_upd_q ? sum : operand) : out_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q    <= MODE_HIST;
      s1_vld_q  <= 1'b0;
      s1_upd_q  <= 1'b0;
      s1_addr_q <= '0;
      s1_add_q  <= '0;
      s2_vld_q  <= 1'b0;
      s2_upd_q  <= 1'b0;
      s2_addr_q <= '0;
      s2_add_q  <= '0;
      fwd_q     <= 1'b0;
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else begin
      mode_q    <= pha_mode_e'(mode_sel);
      s1_vld_q  <= s1_vld_d;
      s1_upd_q  <= s1_upd_d;
      s1_addr_q <= s1_addr_d;
      s1_add_q  <= s1_add_d;
      s2_vld_q  <= s2_vld_d;
      s2_upd_q  <= s2_upd_d;
      s2_addr_q <= s2_addr_d;
      s2_add_q  <= s2_add_d;
      fwd_q     <= fwd_d;
      out_vld_q <= out_vld_d;
      out_q     <= out_d;
    end
  end

  assign dout       = rd_n ? '0 : out_q;
  assign dout_valid = !rd_n & out_vld_q;
endmodule

// File: rtl/pha_checker.sv
module pha_checker #(
  parameter int PIX_W = 10,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             mode_sel,
  input logic             busy,
  input logic [CNT_W-1:0] dout,
  input logic             dout_valid
);
  localparam int DEPTH = 1 << PIX_W;

  logic [PIX_W+1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (!clr_n || !busy)  run_cnt <= '0;
    else if (run_cnt != '1)    run_cnt <= run_cnt + 1'b1;
  end

  // R7: no result leaves the block during a sweep
  p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_valid);

  // R11: a clear request empties the output register
  p_clear_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!dout_valid && dout == '0));

  // R10: a mode change empties the output register
  p_mode_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != $past(mode_sel)) |=> (!dout_valid && dout == '0));

  // R6: a sweep cannot finish on a cycle that requested a clear
  p_sweep_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(clr_n));

  // R6: a sweep is bounded by the table depth (plus reset release slack)
  p_sweep_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(run_cnt) <= DEPTH + 2));
endmodule

bind pix_hist_acc pha_checker #(.PIX_W(PIX_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .mode_sel(mode_sel),
  .busy(busy), .dout(dout), .dout_valid(dout_valid)
);

// File: tb/pix_hist_acc_tb_top.sv
`timescale 1ns/1ps
module pix_hist_acc_tb_top;
  localparam int PIX_W = 10;
  localparam int CNT_W = 24;
  localparam int NVEC  = 20;
  localparam int VW    = 2 + PIX_W + CNT_W;

  // {mode, start_n, pix, din}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 10'h003, 24'h00_0055},
    {1'b0, 1'b0, 10'h003, 24'h00_1234},
    {1'b0, 1'b0, 10'h003, 24'h00_0000},
    {1'b0, 1'b0, 10'h007, 24'h00_0009},
    {1'b0, 1'b0, 10'h003, 24'h00_0000},
    {1'b0, 1'b1, 10'h003, 24'h00_0000},
    {1'b0, 1'b1, 10'h003, 24'h00_0000},
    {1'b0, 1'b0, 10'h3FF, 24'h00_0000},
    {1'b0, 1'b0, 10'h000, 24'h00_0000},
    {1'b0, 1'b1, 10'h007, 24'h00_0000},
    {1'b0, 1'b0, 10'h007, 24'h00_0000},
    {1'b0, 1'b0, 10'h003, 24'h00_0000},
    {1'b1, 1'b0, 10'h003, 24'h00_0010},
    {1'b1, 1'b0, 10'h003, 24'h00_0005},
    {1'b1, 1'b1, 10'h003, 24'h00_0100},
    {1'b1, 1'b0, 10'h020, 24'hFF_FFFF},
    {1'b1, 1'b0, 10'h020, 24'h00_0002},
    {1'b1, 1'b0, 10'h007, 24'h00_0000},
    {1'b1, 1'b1, 10'h020, 24'h00_0007},
    {1'b1, 1'b0, 10'h3FF, 24'h0A_BCDE}
  };

  logic             clk = 1'b0;
  logic             rst_n, mode_sel, start_n, clr_n, rd_n;
  logic [PIX_W-1:0] pix_in;
  logic [CNT_W-1:0] din;
  logic [CNT_W-1:0] dout;
  logic             dout_valid, busy;

  int checks = 0;
  int errors = 0;
  logic [CNT_W-1:0] model [1 << PIX_W];

  always #5 clk = ~clk;

  pix_hist_acc #(.PIX_W(PIX_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .start_n(start_n),
    .pix_in(pix_in), .din(din), .clr_n(clr_n), .rd_n(rd_n),
    .dout(dout), .dout_valid(dout_valid), .busy(busy)
  );

  task automatic chk(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    start_n = 1'b1;
    pix_in  = '0;
    din     = '0;
  endtask

  task automatic model_clear();
    for (int i = 0; i < (1 << PIX_W); i++) model[i] = '0;
  endtask

  // one pixel in, result checked three edges later
  task automatic one(input logic en_n, input logic [PIX_W-1:0] p,
                     input logic [CNT_W-1:0] d, input logic [CNT_W-1:0] exp, input string tag);
    @(negedge clk);
    start_n = en_n; pix_in = p; din = d;
    @(negedge clk); idle();
    @(negedge clk);
    @(negedge clk);
    chk({tag, " valid"}, CNT_W'(dout_valid), CNT_W'(1));
    chk({tag, " data"}, dout, exp);
  endtask

  task automatic run_vecs(input int lo, input int hi);
    logic [CNT_W-1:0] exp_v [NVEC];
    string            tag_v [NVEC];
    @(negedge clk);
    mode_sel = VEC[lo][VW-1];
    idle();
    @(negedge clk);
    for (int i = lo; i <= hi + 3; i++) begin
      @(negedge clk);
      if (i - 3 >= lo) begin
        chk({tag_v[i-3], " valid"}, CNT_W'(dout_valid), CNT_W'(1));
        chk({tag_v[i-3], " data"}, dout, exp_v[i-3]);
      end
      if (i <= hi) begin
        logic             m, en;
        logic [PIX_W-1:0] p;
        logic [CNT_W-1:0] d, old_v, new_v;
        m  = VEC[i][VW-1];
        en = VEC[i][VW-2];
        p  = VEC[i][CNT_W +: PIX_W];
        d  = VEC[i][CNT_W-1:0];
        mode_sel = m; start_n = en; pix_in = p; din = d;
        old_v = model[p];
        if (!en) begin
          new_v = old_v + (m ? d : CNT_W'(1));
          model[p] = new_v;
          exp_v[i] = new_v;
          tag_v[i] = m ? "R2 accumulate" : "R1 histogram";
          if (m && new_v < old_v) tag_v[i] = "R3 wrap";
        end else begin
          exp_v[i] = old_v;
          tag_v[i] = "R4 disabled read";
        end
        if (i > lo && VEC[i-1][CNT_W +: PIX_W] == p) tag_v[i] = {tag_v[i], " R5 back-to-back"};
      end else begin
        idle();
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; mode_sel = 1'b0; clr_n = 1'b1; rd_n = 1'b0;
    idle();
    model_clear();
    repeat (3) @(negedge clk);
    chk("R8 busy in reset", CNT_W'(busy), CNT_W'(1));
    chk("R8 no valid in reset", CNT_W'(dout_valid), CNT_W'(0));
    rst_n = 1'b1;

    // R7: pixels offered during the reset sweep are ignored
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      n++;
      start_n = 1'b0; pix_in = 10'h009; din = '0;
      if (k > 2) chk("R7 no output while busy", CNT_W'(dout_valid), CNT_W'(0));
    end
    idle();
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (n < 1024 || n > 1030) begin
      errors++;
      $display("FAIL R8 reset sweep length actual=%0d expected=1024..1030", n);
    end
    one(1'b1, 10'h009, '0, '0, "R7 bin untouched by busy input");

    // table walk: histogram part then bin-accumulate part
    run_vecs(0, 11);
    run_vecs(12, NVEC - 1);
    one(1'b1, 10'h003, 24'h000777, model[10'h003], "R4 bin unchanged after disabled reads");

    // R9: output enable
    @(negedge clk);
    rd_n = 1'b1; start_n = 1'b1; pix_in = 10'h003;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 valid gated", CNT_W'(dout_valid), CNT_W'(0));
      chk("R9 data gated", dout, '0);
    end
    rd_n = 1'b0;
    #1;
    chk("R9 data driven when enabled", dout, model[10'h003]);

    // R10: mode change empties the pipeline
    @(negedge clk);
    mode_sel = 1'b0;
    @(negedge clk);
    chk("R10 valid after mode change", CNT_W'(dout_valid), CNT_W'(0));
    chk("R10 data after mode change", dout, '0);
    @(negedge clk);
    chk("R10 valid second cycle", CNT_W'(dout_valid), CNT_W'(0));

    // R11 / R6: clear request and sweep length
    repeat (4) @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    chk("R11 valid after clear", CNT_W'(dout_valid), CNT_W'(0));
    chk("R11 data after clear", dout, '0);
    chk("R6 busy after clear", CNT_W'(busy), CNT_W'(1));
    n = 0;
    while (busy && n < 3000) begin
      n++;
      @(negedge clk);
    end
    chk("R6 sweep length", CNT_W'(n), CNT_W'(1024));
    model_clear();
    one(1'b1, 10'h003, '0, '0, "R6 bin 3 zeroed");
    one(1'b1, 10'h3FF, '0, '0, "R6 last bin zeroed");
    one(1'b1, 10'h020, '0, '0, "R6 bin 32 zeroed");
    one(1'b0, 10'h003, '0, 24'h000001, "R1 count after clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule